// File: doc/BRIEF.md
# Inbound Doorbell Queue

This block takes inbound doorbell events from the link side and keeps them in a circular queue in local storage. Each event carries a 16-bit target ID, a 16-bit source ID and a 16-bit info word. The block stores each event as one 8-byte entry at the enqueue pointer and then advances that pointer. While the queue holds entries, a status flag and the interrupt line are raised.

Software reads the entry at the dequeue pointer through a separate read port into the queue storage. To retire that entry it sets a self-clearing bit in the mode register, which moves the dequeue pointer forward by one entry. When the queue cannot take an event, the block holds its ready low and flags a queue-full condition instead of overwriting data. A transaction-error strobe from the link side is latched as a third status flag.

The queue is aligned to its own size: 512 entries of 8 bytes, so 4096 bytes. The low 12 bits of each pointer are the byte offset of an entry, and the upper bits come from a base register. Writing that base register points both pointers at the start of the queue.

Top module: `doorbell_inq`

## Requirements
- R1: After reset, the mode, status and both pointer offsets are zero, `db_ready` is low and `irq` is low.
- R2: The queue accepts events only while mode bit 0 (enable) is 1. With enable at 0, `db_ready` is low and an offered event leaves the enqueue pointer unchanged.
- R3: An event is accepted on a clock edge where `db_valid` and `db_ready` are both high. It is stored at the enqueue offset as a 64-bit entry: bits 63:48 zero, 47:32 target ID, 31:16 source ID, 15:0 info. The enqueue pointer then reads 8 bytes higher.
- R4: A write to the mode register (word 0) with bit 1 set advances the dequeue pointer by 8 bytes if the queue is not empty, and does nothing to it if the queue is empty. Bit 1 always reads back as 0, and the other written bits read back as written.
- R5: Pointer offsets wrap modulo 4096. A pointer register reads as {base bits 31:12, 12-bit offset}.
- R6: Status bit 0 (not-empty) sets when an event is accepted. Writing 1 to it clears it only if the queue is empty after that cycle; otherwise it stays 1.
- R7: The queue holds at most 511 entries. When it holds 511, `db_ready` is low, and an event offered while enable is 1 sets status bit 4 (full).
- R8: A `db_err` pulse sets status bit 7. Status bits 4 and 7 clear when 1 is written to them, but a set in the same cycle wins.
- R9: `irq` is high exactly when any of status bits 0, 4 or 7 is high.
- R10: A write to the base register (word 4) keeps bits 31:12 as the queue base and loads both pointer offsets with zero. The dequeue pointer (word 2) and enqueue pointer (word 3) are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Inbound doorbell event offered |
| db_ready | output | 1 | Queue can take the event this cycle |
| db_tgt_id | input | 16 | Target ID of the event |
| db_src_id | input | 16 | Source ID of the event |
| db_info | input | 16 | Info word of the event |
| db_err | input | 1 | Transaction-error strobe from the link side |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0 mode, 1 status, 2 dequeue ptr, 3 enqueue ptr, 4 base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| q_rd_off | input | 12 | Byte offset of the queue entry to read |
| q_rd_data | output | 64 | Entry at q_rd_off, combinational |
| irq | output | 1 | Interrupt, OR of the status flags |

## Verification
Register reads and the queue read port are combinational. Every state change is due exactly one clock edge after the cycle that causes it: an accepted event, a dequeue write, a status clear, an error pulse or a base write. The bench drives all inputs on the falling edge and holds them for one full cycle. After the rising edge it samples at the following falling edge plus one time unit, so each result is read in the first cycle it is due. `db_ready` is combinational from the mode register and the pointers, and it is checked in the same cycle as the pointer values that set it.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int unsigned ENTRY_BYTES = 8;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_STAT = 3'd1,
    RA_DQ   = 3'd2,
    RA_EQ   = 3'd3,
    RA_BASE = 3'd4
  } reg_addr_e;

  localparam int unsigned MODE_EN  = 0;
  localparam int unsigned MODE_DEQ = 1;
  localparam int unsigned ST_NE    = 0;
  localparam int unsigned ST_FULL  = 4;
  localparam int unsigned ST_ERR   = 7;

  typedef struct packed {
    logic [15:0] pad;
    logic [15:0] tgt;
    logic [15:0] src;
    logic [15:0] info;
  } entry_t;

  function automatic entry_t pack_entry(input logic [15:0] tgt,
                                        input logic [15:0] src,
                                        input logic [15:0] info);
    entry_t e;
    e.pad  = 16'h0000;
    e.tgt  = tgt;
    e.src  = src;
    e.info = info;
    return e;
  endfunction

  // Byte offset of the following entry; span is a power of two.
  function automatic logic [31:0] off_step(input logic [31:0] off,
                                           input logic [31:0] span);
    return (off + ENTRY_BYTES) & (span - 32'd1);
  endfunction
endpackage

// File: rtl/dbq_store.sv
module dbq_store #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  dbq_pkg::entry_t       wdata,
  input  logic [IDX_W-1:0]      ridx,
  output dbq_pkg::entry_t       rdata
);
  dbq_pkg::entry_t mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/dbq_ptrs.sv
module dbq_ptrs #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned OFF_W = $clog2(ENTRIES * dbq_pkg::ENTRY_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rebase,
  input  logic             push,
  input  logic             deq_req,
  output logic [OFF_W-1:0] dq_off,
  output logic [OFF_W-1:0] eq_off,
  output logic             empty,
  output logic             full,
  output logic             deq_fire
);
  import dbq_pkg::*;
  localparam logic [31:0] SPAN = 32'(ENTRIES * ENTRY_BYTES);

  logic [31:0]      dq_wide, eq_wide;
  logic [OFF_W-1:0] dq_step, eq_step;

  assign dq_wide = off_step(32'(dq_off), SPAN);
  assign eq_wide = off_step(32'(eq_off), SPAN);
  assign dq_step = dq_wide[OFF_W-1:0];
  assign eq_step = eq_wide[OFF_W-1:0];

  assign empty    = (dq_off == eq_off);
  assign full     = (eq_step == dq_off);
  assign deq_fire = deq_req && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || rebase) begin
      dq_off <= '0;
      eq_off <= '0;
    end else begin
      if (push)     eq_off <= eq_step;
      if (deq_fire) dq_off <= dq_step;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R7
  AST_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !deq_fire && !rebase) |=> !empty);  // R3
  AST_DEQ_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && empty && !rebase) |=> $stable(dq_off));  // R4
endmodule

// File: rtl/dbq_ctrl.sv
module dbq_ctrl #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned OFF_W = $clog2(ENTRIES * dbq_pkg::ENTRY_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [OFF_W-1:0] dq_off,
  input  logic [OFF_W-1:0] eq_off,
  input  logic             empty,
  input  logic             full,
  input  logic             push_fire,
  input  logic             db_valid,
  input  logic             db_err,
  output logic             mode_en,
  output logic             deq_req,
  output logic             rebase,
  output logic             irq
);
  import dbq_pkg::*;

  logic [31:0]       mode_q;
  logic [31-OFF_W:0] base_hi;
  logic              st_ne, st_full, st_err;
  logic              wr_mode, wr_stat;
  logic [31:0]       clr;
  logic              full_hit;

  assign wr_mode  = reg_wr && (reg_addr == RA_MODE);
  assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
  assign rebase   = reg_wr && (reg_addr == RA_BASE);
  assign clr      = wr_stat ? reg_wdata : 32'h0;
  assign deq_req  = wr_mode && reg_wdata[MODE_DEQ];
  assign mode_en  = mode_q[MODE_EN];
  assign full_hit = db_valid && mode_en && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      base_hi <= '0;
      st_ne   <= 1'b0;
      st_full <= 1'b0;
      st_err  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata & ~(32'd1 << MODE_DEQ);
      if (rebase)  base_hi <= reg_wdata[31:OFF_W];
      if (clr[ST_NE])   st_ne <= !empty || push_fire;
      else if (push_fire) st_ne <= 1'b1;
      st_full <= (st_full && !clr[ST_FULL]) || full_hit;
      st_err  <= (st_err && !clr[ST_ERR]) || db_err;
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    unique case (reg_addr)
      RA_MODE: reg_rdata = mode_q;
      RA_STAT: begin
        reg_rdata[ST_NE]   = st_ne;
        reg_rdata[ST_FULL] = st_full;
        reg_rdata[ST_ERR]  = st_err;
      end
      RA_DQ:   reg_rdata = {base_hi, dq_off};
      RA_EQ:   reg_rdata = {base_hi, eq_off};
      RA_BASE: reg_rdata = {base_hi, {OFF_W{1'b0}}};
      default: reg_rdata = 32'h0;
    endcase
  end

  assign irq = st_ne || st_full || st_err;

  AST_NE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> st_ne);  // R6
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> st_full);  // R7
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> st_err);  // R8
  AST_NE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ne && !empty && !rebase) |=> st_ne);  // R6
endmodule

// File: rtl/doorbell_inq.sv
module doorbell_inq #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned OFF_W = $clog2(ENTRIES * dbq_pkg::ENTRY_BYTES),
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_valid,
  output logic             db_ready,
  input  logic [15:0]      db_tgt_id,
  input  logic [15:0]      db_src_id,
  input  logic [15:0]      db_info,
  input  logic             db_err,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [OFF_W-1:0] q_rd_off,
  output logic [63:0]      q_rd_data,
  output logic             irq
);
  import dbq_pkg::*;
  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic             mode_en, deq_req, rebase;
  logic             empty, full, deq_fire, push_fire;
  logic [OFF_W-1:0] dq_off, eq_off;
  entry_t           rd_entry;

  assign db_ready  = mode_en && !full;
  assign push_fire = db_valid && db_ready;

  dbq_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dq_off(dq_off),
    .eq_off(eq_off), .empty(empty), .full(full), .push_fire(push_fire),
    .db_valid(db_valid), .db_err(db_err), .mode_en(mode_en),
    .deq_req(deq_req), .rebase(rebase), .irq(irq)
  );

  dbq_ptrs #(.ENTRIES(ENTRIES)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .rebase(rebase), .push(push_fire),
    .deq_req(deq_req), .dq_off(dq_off), .eq_off(eq_off), .empty(empty),
    .full(full), .deq_fire(deq_fire)
  );

  dbq_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .we(push_fire), .widx(eq_off[OFF_W-1:SHIFT]),
    .wdata(pack_entry(db_tgt_id, db_src_id, db_info)),
    .ridx(q_rd_off[OFF_W-1:SHIFT]), .rdata(rd_entry)
  );

  assign q_rd_data = rd_entry;

  AST_DISABLED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !db_ready);  // R2
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> irq);  // R9
endmodule

// File: tb/sim_doorbell_inq.sv
module sim_doorbell_inq;
  logic        clk = 0, rst_n = 0;
  logic        db_valid = 0, db_err = 0, reg_wr = 0;
  logic [15:0] db_tgt_id = 0, db_src_id = 0, db_info = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [11:0] q_rd_off = 0;
  logic [63:0] q_rd_data;
  logic        db_ready, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  doorbell_inq u0 (.*);

  localparam logic [47:0] VEC [6] = '{
    48'h0012_0034_1000, 48'h00ff_0001_ffff, 48'hbeef_cafe_0000,
    48'h0001_0002_8001, 48'hffff_ffff_0a5a, 48'h7e7e_0303_4242};

  localparam logic [31:0] BASE = 32'h0004_5000;
  localparam logic [31:0] MODE_ON = 32'h0010_8161;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [47:0] v);
    @(negedge clk); db_valid = 1; {db_tgt_id, db_src_id, db_info} = v;
    @(negedge clk); db_valid = 0;
  endtask

  task automatic deq_n(input int n);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd0; reg_wdata = MODE_ON | 32'h2;
    repeat (n) @(negedge clk);
    reg_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", db_ready, 0);
    chk("R1 irq", irq, 0);
    rd(3'd0, r); chk("R1 mode", r, 0);
    rd(3'd1, r); chk("R1 status", r, 0);
    rd(3'd2, r); chk("R1 dq", r, 0);
    rd(3'd3, r); chk("R1 eq", r, 0);

    // R10 base load
    wr(3'd4, BASE | 32'h0abc);
    rd(3'd2, r); chk("R10 dq base", r, BASE);
    rd(3'd3, r); chk("R10 eq base", r, BASE);

    // R2 disabled: event not accepted
    chk("R2 ready disabled", db_ready, 0);
    push(VEC[0]);
    rd(3'd3, r); chk("R2 eq unchanged", r, BASE);

    // R4 dequeue bit on empty queue, bit1 reads 0
    wr(3'd0, MODE_ON | 32'h2);
    rd(3'd0, r); chk("R4 mode readback", r, MODE_ON);
    rd(3'd2, r); chk("R4 dq unchanged empty", r, BASE);
    chk("R2 ready enabled", db_ready, 1);

    // R3 vector table
    for (int i = 0; i < 6; i++) begin
      push(VEC[i]);
      rd(3'd3, r); chk("R3 eq advance", r, BASE + 32'(8 * (i + 1)));
    end
    rd(3'd1, r); chk("R6 not-empty set", r, 32'h1);
    chk("R9 irq on entries", irq, 1);
    for (int i = 0; i < 6; i++) begin
      q_rd_off = 12'(8 * i); #1;
      chk("R3 entry layout", q_rd_data, {16'h0, VEC[i]});
    end

    // R6 clear while non-empty
    wr(3'd1, 32'h1);
    rd(3'd1, r); chk("R6 clear kept", r, 32'h1);

    // R4 dequeue
    deq_n(1);
    rd(3'd2, r); chk("R4 dq advance", r, BASE + 32'd8);
    deq_n(5);
    rd(3'd2, r); chk("R4 dq at eq", r, BASE + 32'd48);
    wr(3'd1, 32'h1);
    rd(3'd1, r); chk("R6 clear when empty", r, 32'h0);
    chk("R9 irq low", irq, 0);

    // R7 / R5 fill to capacity from offset 48
    @(negedge clk);
    db_valid = 1; db_tgt_id = 16'h00a1; db_src_id = 16'h00b2;
    for (int i = 0; i < 511; i++) begin
      db_info = 16'(i);
      @(negedge clk);
    end
    #1;
    chk("R7 ready low when full", db_ready, 0);
    rd(3'd3, r); chk("R5 eq wrapped", r, BASE + 32'd40);
    @(negedge clk); db_valid = 0;
    rd(3'd1, r); chk("R7 full flag", r, 32'h11);
    q_rd_off = 12'd0; #1;
    chk("R5 entry after wrap", q_rd_data, {16'h0, 16'h00a1, 16'h00b2, 16'd506});
    q_rd_off = 12'd4088; #1;
    chk("R5 last entry before wrap", q_rd_data, {16'h0, 16'h00a1, 16'h00b2, 16'd505});

    // R5 dequeue wraps
    deq_n(511);
    rd(3'd2, r); chk("R5 dq wrapped", r, BASE + 32'd40);
    wr(3'd1, 32'h11);
    rd(3'd1, r); chk("R8 clear full", r, 32'h0);

    // R8 error strobe
    @(negedge clk); db_err = 1;
    @(negedge clk); db_err = 0;
    rd(3'd1, r); chk("R8 error set", r, 32'h80);
    chk("R9 irq on error", irq, 1);
    wr(3'd1, 32'h80);
    rd(3'd1, r); chk("R8 error clear", r, 32'h0);

    // R10 rebase with entries present
    push(VEC[1]);
    push(VEC[2]);
    wr(3'd4, 32'h0008_0000);
    rd(3'd2, r); chk("R10 dq rebase", r, 32'h0008_0000);
    rd(3'd3, r); chk("R10 eq rebase", r, 32'h0008_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule